// File: doc/BRIEF.md
# Matrix Key-Set Ghost Filter and Event Sequencer

This block sits after a keyboard matrix scanner. Each time a scan completes, it takes a snapshot of up to eight key slots. Each slot carries a valid flag, a row and a column. The block packs the valid slots into a list of scancodes. It can move every scancode into a second layer while a designated function key is held, and it then drops that key from the list. It can also refuse a scan that looks like matrix ghosting. When a scan is accepted, the block compares the new list with the list it accepted last time. It then sends a stream of key events, one per handshake, to a downstream consumer. Releases come first and presses follow.

The accepted list is kept inside the block. Nothing outside has to remember which keys are held. While the block is still working through a snapshot, the `busy` output is high and further snapshot strobes are ignored. The ghost check walks every pair of keys in turn. The time it takes depends only on how many keys are in the scan.

Top module: `keyset_event_gen`

## Requirements
- R1: A scancode is formed as row*8 + column (row in bits 6:3, column in bits 2:0). Bit 7 is the layer bit, and it is clear for ordinary keys.
- R2: Slots whose valid flag is low are skipped. Valid slots enter the new list in ascending slot order.
- R3: With the ghost filter on and three or more keys in the list, the scan is refused when some pair of keys shares a row and some pair shares a column. A refused scan emits no events and leaves the held list unchanged.
- R4: With the ghost filter off, or with fewer than three keys, or when only rows (or only columns) coincide, the scan is accepted.
- R5: With the layer mode on and the function key (row 7, column 2, scancode 58) present, that key emits nothing. Every other key in the scan is reported with bit 7 set (scancode + 128).
- R6: With the layer mode off, the function key is an ordinary key with scancode 58.
- R7: An accepted scan first emits a release (`ev_press`=0) for each held key that is absent from the new list, in held order. It then emits a press (`ev_press`=1) for every key of the new list, in list order. The new list then becomes the held list.
- R8: An empty snapshot releases every held key and leaves the held list empty, so the next scan emits no releases.
- R9: An event is consumed only when `ev_valid` and `ev_ready` are both high. While it waits, its code and kind stay unchanged.
- R10: `busy` is low after reset and rises in the cycle after an accepted strobe. Strobes that arrive while `busy` is high are ignored.
- R11: With the ghost filter on and n ≥ 3 keys, the ghost decision takes n(n-1)/2 cycles. Otherwise it takes 1 cycle. The release phase takes (held count + 1) cycles and the press phase takes (new count + 1) cycles when `ev_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snap_valid | input | 1 | One-cycle strobe: a snapshot is present |
| snap_ent_valid | input | 8 | Per-slot valid flags |
| snap_rows | input | 32 | Row of each slot, 4 bits per slot |
| snap_cols | input | 24 | Column of each slot, 3 bits per slot |
| ghost_en | input | 1 | Enable ghost rejection |
| fn_en | input | 1 | Enable function-layer remap |
| busy | output | 1 | Snapshot being processed |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Consumer accepts the event |
| ev_press | output | 1 | 1 = press, 0 = release |
| ev_code | output | 8 | Scancode of the event |

## Verification
The hardest case to reach is a snapshot strobe that lands while a sequence is still draining. The block must ignore it entirely, and its effect can only be seen in the release list of a later scan. To reach it, the bench raises a second strobe with different keys partway through a busy period. The following scan then has to release exactly the keys of the first snapshot. A refused ghost scan is handled the same way: a follow-up scan shows that the held list was left intact. Throttled ready patterns keep events waiting across several cycles.

// File: rtl/keyset_pkg.sv
package keyset_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GHOST = 2'd1,
        ST_REL   = 2'd2,
        ST_PRS   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/keyset_capture.sv
// Packs valid slots into a scancode list and applies the function-layer remap.
module keyset_capture #(
    parameter int MAX_KEYS = 8,
    parameter int ROW_W    = 4,
    parameter int COL_W    = 3,
    parameter int FN_CODE  = 58,
    localparam int KEY_W   = ROW_W + COL_W,
    localparam int CODE_W  = KEY_W + 1,
    localparam int CNT_W   = $clog2(MAX_KEYS + 1),
    localparam int IDX_W   = $clog2(MAX_KEYS)
) (
    input  logic [MAX_KEYS-1:0]             ent_valid,
    input  logic [MAX_KEYS*ROW_W-1:0]       rows,
    input  logic [MAX_KEYS*COL_W-1:0]       cols,
    input  logic                            fn_en,
    output logic [MAX_KEYS-1:0][CODE_W-1:0] codes,
    output logic [CNT_W-1:0]                cnt,
    output logic                            fn_seen
);
    logic [KEY_W-1:0] key;

    always_comb begin
        codes   = '0;
        cnt     = '0;
        fn_seen = 1'b0;
        key     = '0;
        for (int i = 0; i < MAX_KEYS; i++) begin
            if (ent_valid[i]) begin
                key = {rows[i*ROW_W +: ROW_W], cols[i*COL_W +: COL_W]};
                if (fn_en && (key == KEY_W'(FN_CODE))) begin
                    fn_seen = 1'b1;
                end else begin
                    codes[cnt[IDX_W-1:0]] = {1'b0, key};
                    cnt = cnt + CNT_W'(1);
                end
            end
        end
        if (fn_seen) begin
            for (int i = 0; i < MAX_KEYS; i++) begin
                if (CNT_W'(i) < cnt) codes[i][CODE_W-1] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/keyset_ghost.sv
// Walks all key pairs, one per cycle, and records row and column coincidences.
module keyset_ghost #(
    parameter int MAX_KEYS = 8,
    parameter int ROW_W    = 4,
    parameter int COL_W    = 3,
    localparam int KEY_W   = ROW_W + COL_W,
    localparam int CNT_W   = $clog2(MAX_KEYS + 1),
    localparam int IDX_W   = $clog2(MAX_KEYS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           go,
    input  logic                           enable,
    input  logic [CNT_W-1:0]               cnt,
    input  logic [MAX_KEYS-1:0][KEY_W-1:0] keys,
    output logic                           done,
    output logic                           ghost
);
    typedef struct packed {
        logic [CNT_W-1:0] i;
        logic [CNT_W-1:0] j;
        logic             row_hit;
        logic             col_hit;
    } gh_t;

    gh_t q, d;
    logic short_scan, last_pair, same_row, same_col;
    logic [KEY_W-1:0] key_a, key_b;

    always_comb begin
        d          = q;
        done       = 1'b0;
        ghost      = 1'b0;
        short_scan = !enable || (cnt < CNT_W'(3));
        key_a      = keys[q.i[IDX_W-1:0]];
        key_b      = keys[q.j[IDX_W-1:0]];
        same_row   = key_a[KEY_W-1:COL_W] == key_b[KEY_W-1:COL_W];
        same_col   = key_a[COL_W-1:0] == key_b[COL_W-1:0];
        last_pair  = (q.i == cnt - CNT_W'(2)) && (q.j == cnt - CNT_W'(1));
        if (!go) begin
            d.i       = '0;
            d.j       = CNT_W'(1);
            d.row_hit = 1'b0;
            d.col_hit = 1'b0;
        end else if (short_scan) begin
            done = 1'b1;
        end else begin
            d.row_hit = q.row_hit | same_row;
            d.col_hit = q.col_hit | same_col;
            if (last_pair) begin
                done      = 1'b1;
                ghost     = d.row_hit && d.col_hit;
                d.i       = '0;
                d.j       = CNT_W'(1);
                d.row_hit = 1'b0;
                d.col_hit = 1'b0;
            end else if (q.j == cnt - CNT_W'(1)) begin
                d.i = q.i + CNT_W'(1);
                d.j = q.i + CNT_W'(2);
            end else begin
                d.j = q.j + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{i: '0, j: CNT_W'(1), row_hit: 1'b0, col_hit: 1'b0};
        end else begin
            q <= d;
        end
    end

    // R11: the pair walk stays inside the list, second index above the first
    a_r11_pair_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (go && enable && cnt >= CNT_W'(3)) |-> (q.j > q.i) && (q.j < cnt));
endmodule

// File: rtl/keyset_member.sv
// Tells whether one scancode occurs in the first cnt entries of a list.
module keyset_member #(
    parameter int MAX_KEYS = 8,
    parameter int CODE_W   = 8,
    localparam int CNT_W   = $clog2(MAX_KEYS + 1)
) (
    input  logic [CODE_W-1:0]               code,
    input  logic [MAX_KEYS-1:0][CODE_W-1:0] list,
    input  logic [CNT_W-1:0]                cnt,
    output logic                            hit
);
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < MAX_KEYS; i++) begin
            if ((CNT_W'(i) < cnt) && (list[i] == code)) hit = 1'b1;
        end
    end
endmodule

// File: rtl/keyset_event_gen.sv
module keyset_event_gen
    import keyset_pkg::*;
#(
    parameter int MAX_KEYS = 8,
    parameter int ROW_W    = 4,
    parameter int COL_W    = 3,
    parameter int FN_CODE  = 58,
    localparam int KEY_W   = ROW_W + COL_W,
    localparam int CODE_W  = KEY_W + 1,
    localparam int CNT_W   = $clog2(MAX_KEYS + 1),
    localparam int IDX_W   = $clog2(MAX_KEYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      snap_valid,
    input  logic [MAX_KEYS-1:0]       snap_ent_valid,
    input  logic [MAX_KEYS*ROW_W-1:0] snap_rows,
    input  logic [MAX_KEYS*COL_W-1:0] snap_cols,
    input  logic                      ghost_en,
    input  logic                      fn_en,
    output logic                      busy,
    output logic                      ev_valid,
    input  logic                      ev_ready,
    output logic                      ev_press,
    output logic [CODE_W-1:0]         ev_code
);
    typedef struct packed {
        seq_state_e                     state;
        logic [MAX_KEYS-1:0][CODE_W-1:0] old_codes;
        logic [CNT_W-1:0]               old_cnt;
        logic [MAX_KEYS-1:0][CODE_W-1:0] new_codes;
        logic [CNT_W-1:0]               new_cnt;
        logic                           fn_hit;
        logic [CNT_W-1:0]               k;
    } seq_t;

    seq_t q, d;

    logic [MAX_KEYS-1:0][CODE_W-1:0] cap_codes;
    logic [CNT_W-1:0]                cap_cnt;
    logic                            cap_fn;
    logic [MAX_KEYS-1:0][KEY_W-1:0]  scan_keys;
    logic                            g_done, g_ghost;
    logic                            old_in_new;
    logic [IDX_W-1:0]                k_idx;

    assign k_idx = q.k[IDX_W-1:0];

    keyset_capture #(
        .MAX_KEYS(MAX_KEYS), .ROW_W(ROW_W), .COL_W(COL_W), .FN_CODE(FN_CODE)
    ) u_capture (
        .ent_valid(snap_ent_valid),
        .rows     (snap_rows),
        .cols     (snap_cols),
        .fn_en    (fn_en),
        .codes    (cap_codes),
        .cnt      (cap_cnt),
        .fn_seen  (cap_fn)
    );

    for (genvar g = 0; g < MAX_KEYS; g++) begin : g_keys
        assign scan_keys[g] = q.new_codes[g][KEY_W-1:0];
    end

    keyset_ghost #(
        .MAX_KEYS(MAX_KEYS), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_ghost (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (q.state == ST_GHOST),
        .enable(ghost_en),
        .cnt   (q.new_cnt),
        .keys  (scan_keys),
        .done  (g_done),
        .ghost (g_ghost)
    );

    keyset_member #(
        .MAX_KEYS(MAX_KEYS), .CODE_W(CODE_W)
    ) u_member (
        .code(q.old_codes[k_idx]),
        .list(q.new_codes),
        .cnt (q.new_cnt),
        .hit (old_in_new)
    );

    always_comb begin
        d        = q;
        ev_valid = 1'b0;
        ev_press = 1'b0;
        ev_code  = '0;
        case (q.state)
            ST_IDLE: begin
                if (snap_valid) begin
                    d.new_codes = cap_codes;
                    d.new_cnt   = cap_cnt;
                    d.fn_hit    = cap_fn;
                    d.k         = '0;
                    d.state     = ST_GHOST;
                end
            end
            ST_GHOST: begin
                if (g_done) begin
                    d.k     = '0;
                    d.state = g_ghost ? ST_IDLE : ST_REL;
                end
            end
            ST_REL: begin
                if (q.k == q.old_cnt) begin
                    d.k     = '0;
                    d.state = ST_PRS;
                end else if (!old_in_new) begin
                    ev_valid = 1'b1;
                    ev_code  = q.old_codes[k_idx];
                    if (ev_ready) d.k = q.k + CNT_W'(1);
                end else begin
                    d.k = q.k + CNT_W'(1);
                end
            end
            ST_PRS: begin
                if (q.k == q.new_cnt) begin
                    d.old_codes = q.new_codes;
                    d.old_cnt   = q.new_cnt;
                    d.state     = ST_IDLE;
                end else begin
                    ev_valid = 1'b1;
                    ev_press = 1'b1;
                    ev_code  = q.new_codes[k_idx];
                    if (ev_ready) d.k = q.k + CNT_W'(1);
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.state != ST_IDLE);

    // R9: a waiting event keeps its code and kind
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> ev_valid && $stable(ev_code) && $stable(ev_press));

    // R7: once a press is taken, no release follows in the same sequence
    a_r7_press_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && ev_press) |=> !(ev_valid && !ev_press));

    // R10: an idle strobe raises busy in the next cycle
    a_r10_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_valid && !busy) |=> busy);

    // R3: the held count moves only at the close of a press phase
    a_r3_held_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.old_cnt) |-> $past(q.state == ST_PRS));

    // R5: with the layer active every press carries the layer bit
    a_r5_layer_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_press && q.fn_hit) |-> ev_code[CODE_W-1]);

    // R2: list lengths never exceed the slot count
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.new_cnt <= CNT_W'(MAX_KEYS)) && (q.old_cnt <= CNT_W'(MAX_KEYS)));
endmodule

// File: tb/keyset_event_gen_tb.sv
module keyset_event_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NK = 8;
    localparam int FN = 58;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snap_valid = 1'b0;
    logic [7:0]  snap_ent_valid = '0;
    logic [31:0] snap_rows = '0;
    logic [23:0] snap_cols = '0;
    logic        ghost_en = 1'b0;
    logic        fn_en = 1'b0;
    logic        busy, ev_valid, ev_press;
    logic        ev_ready = 1'b1;
    logic [7:0]  ev_code;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    int held[$];
    string cur_tag = "R1";
    bit ready_mode = 1'b0;
    int cyc = 0;

    bit stall_q = 1'b0;
    logic [7:0] st_code;
    logic st_press;

    bit sv[NK];
    int sr[NK];
    int sc[NK];

    always #(CLK_PERIOD/2) clk = ~clk;

    keyset_event_gen u_dut (
        .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid),
        .snap_ent_valid(snap_ent_valid), .snap_rows(snap_rows),
        .snap_cols(snap_cols), .ghost_en(ghost_en), .fn_en(fn_en),
        .busy(busy), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_press(ev_press), .ev_code(ev_code)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        #1;
        cyc++;
        ev_ready = ready_mode ? ((cyc % 3) != 2) : 1'b1;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_q)
                chk(ev_valid && ev_code == st_code && ev_press == st_press,
                    "R9", int'(ev_code), int'(st_code));
            stall_q  = ev_valid && !ev_ready;
            st_code  = ev_code;
            st_press = ev_press;
            if (ev_valid && ev_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_tag, int'({ev_press, ev_code}), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'({ev_press, ev_code}) == e, cur_tag, int'({ev_press, ev_code}), e);
                end
            end
        end
    end

    task automatic clear_stage();
        for (int i = 0; i < NK; i++) begin
            sv[i] = 1'b0; sr[i] = 0; sc[i] = 0;
        end
    endtask

    task automatic put(int slot, int r, int c);
        sv[slot] = 1'b1; sr[slot] = r; sc[slot] = c;
    endtask

    task automatic drive_stage();
        for (int i = 0; i < NK; i++) begin
            snap_ent_valid[i]   = sv[i];
            snap_rows[i*4 +: 4] = sr[i][3:0];
            snap_cols[i*3 +: 3] = sc[i][2:0];
        end
    endtask

    // model of the requirements: builds the expected event list
    task automatic model(bit g, bit f);
        int nl[$];
        bit fn_seen, rh, ch, ghost, found;
        fn_seen = 0; rh = 0; ch = 0; ghost = 0;
        for (int i = 0; i < NK; i++) begin
            if (sv[i]) begin
                if (f && (sr[i]*8 + sc[i]) == FN) fn_seen = 1;
                else nl.push_back(sr[i]*8 + sc[i]);
            end
        end
        if (fn_seen) foreach (nl[i]) nl[i] += 128;
        if (g && nl.size() >= 3) begin
            for (int i = 0; i < nl.size(); i++)
                for (int j = i + 1; j < nl.size(); j++) begin
                    if ((nl[i] % 128) / 8 == (nl[j] % 128) / 8) rh = 1;
                    if (nl[i] % 8 == nl[j] % 8) ch = 1;
                end
            ghost = rh && ch;
        end
        if (!ghost) begin
            foreach (held[i]) begin
                found = 0;
                foreach (nl[j]) if (nl[j] == held[i]) found = 1;
                if (!found) exp_q.push_back(held[i]);
            end
            foreach (nl[i]) exp_q.push_back(256 + nl[i]);
            held = nl;
        end
    endtask

    task automatic run_scan(string tag, bit g, bit f, int exp_busy, bit mid);
        int busy_n;
        cur_tag = tag;
        model(g, f);
        @(negedge clk);
        drive_stage();
        ghost_en = g; fn_en = f;
        snap_valid = 1'b1;
        @(negedge clk);
        snap_valid = 1'b0;
        busy_n = 0;
        while (busy) begin
            busy_n++;
            if (mid && busy_n == 2) begin
                snap_ent_valid = 8'hFF;
                snap_rows = 32'h1234_5678;
                snap_valid = 1'b1;
            end else begin
                snap_valid = 1'b0;
            end
            @(negedge clk);
        end
        snap_valid = 1'b0;
        if (exp_busy >= 0) chk(busy_n == exp_busy, tag, busy_n, exp_busy);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !ev_valid, "R10", int'({busy, ev_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !ev_valid, "R10", int'({busy, ev_valid}), 0);

        // R1: single key, scancode = row*8+col; busy 1+1+2
        clear_stage(); put(0, 1, 2);
        run_scan("R1", 0, 0, 4, 0);
        // R2: slot 1 invalid and skipped
        clear_stage(); put(0, 1, 2); put(2, 3, 5); sr[1] = 6; sc[1] = 6;
        run_scan("R2", 0, 0, 6, 0);
        ready_mode = 1'b1;
        // R7: release first then press, under throttled ready
        clear_stage(); put(0, 3, 5);
        run_scan("R7", 0, 0, -1, 0);
        // R3: L-shaped ghost refused, three pair cycles
        clear_stage(); put(0, 2, 1); put(1, 2, 4); put(2, 5, 1);
        run_scan("R3", 1, 0, 3, 0);
        // R3: held set unchanged -> no releases
        clear_stage(); put(0, 3, 5);
        run_scan("R3", 1, 0, -1, 0);
        // R4: same pattern with filter off is accepted
        clear_stage(); put(0, 2, 1); put(1, 2, 4); put(2, 5, 1);
        run_scan("R4", 0, 0, -1, 0);
        ready_mode = 1'b0;
        // R4: only rows coincide -> accepted; 3 + 4 + 4 cycles
        clear_stage(); put(0, 0, 0); put(1, 0, 1); put(2, 2, 3);
        run_scan("R4", 1, 0, 11, 0);
        // R5: function key hidden, others get layer bit
        clear_stage(); put(0, 7, 2); put(1, 1, 1);
        run_scan("R5", 0, 1, -1, 0);
        clear_stage(); put(0, 1, 1);
        run_scan("R5", 0, 1, -1, 0);
        // R6: function key ordinary when layer mode off
        clear_stage(); put(0, 7, 2);
        run_scan("R6", 0, 0, -1, 0);
        // R8: empty snapshot releases all; 1 + 2 + 1 cycles
        clear_stage();
        run_scan("R8", 0, 0, 4, 0);
        clear_stage(); put(0, 4, 4);
        run_scan("R8", 0, 0, 4, 0);
        // R10: strobe while busy ignored
        clear_stage(); put(0, 6, 0); put(1, 6, 7);
        run_scan("R10", 0, 0, -1, 1);
        clear_stage(); put(0, 6, 0);
        run_scan("R10", 0, 0, -1, 0);
        // R11: four keys, filter on: 6 + 2 + 5 cycles
        clear_stage(); put(0, 0, 0); put(1, 1, 1); put(2, 2, 2); put(3, 3, 3);
        run_scan("R11", 1, 0, 13, 0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule